// File: doc/BRIEF.md
# Keyed Nonvolatile Programming Controller

This block sits on a simple register bus and carries out program and erase operations on a small internal word array. The array stands in for on-chip nonvolatile memory. Firmware sees four 32-bit registers: control, key, address and data. Every register can be written through three aliases. A raw write replaces the value. A set write ORs the bus word into the register. A clear write removes the bus word's bits from the register. This lets firmware change single bits without a read-modify-write.

An operation starts only after a fixed ritual. Firmware loads the operation code and sets write-enable. It then writes three words to the key register in an exact order, and finally raises the start bit. While the operation runs, the start bit reads back as 1, and firmware polls it. When the operation ends, hardware drops the start bit. Two sticky flags report failures. One marks a start that was refused. The other marks an operation that ended while the supply-low input was asserted. Running the no-operation command through the full ritual clears both flags.

Inside, the block has four parts:
- An unlock state machine with the states `LK_IDLE`, `LK_ARMED`, `LK_HALF` and `LK_OPEN`.
- An operation sequencer with a busy counter and the states `SQ_IDLE` and `SQ_RUN`.
- The word array.
- The register file that ties them together.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: `bus_sel[3:2]` selects the register: 0 control, 1 key, 2 address, 3 data. `bus_sel[1:0]` selects the alias: 1 clears the written bits, 2 sets the written bits, 0 and 3 replace the value. Reads ignore the alias. The address and data registers read back the value the alias arithmetic gives.
- R2: Control layout:
  - bit 15 is start/busy, bit 14 is write-enable, bit 13 is the refused-start flag, bit 12 is the supply-low flag, and bits 3:0 hold the operation code.
  - All other bits read 0.
  - Software writes cannot change bits 13 and 12.
  - The key register always reads 0.
- R3: The key register must receive 0x00000000, then 0xAA996655, then 0x556699AA. That takes the unlock machine `LK_IDLE`→`LK_ARMED`→`LK_HALF`→`LK_OPEN`. A write of 0x00000000 to the key register restarts at `LK_ARMED` from any state. Only in `LK_OPEN`, with write-enable 1 and a legal code, does a control write whose result has bit 15 set start the sequencer (`SQ_IDLE`→`SQ_RUN`).
- R4: In `LK_ARMED` or `LK_HALF`, either of these returns the machine to `LK_IDLE`:
  - a wrong key value;
  - a read or write of any other register.

  A later start attempt is then refused: bit 13 is set, no operation runs and the array is untouched.
- R5: A start attempt with write-enable 0 is refused and sets bit 13.
- R6: Any start attempt, accepted or refused, returns the unlock machine to `LK_IDLE`. A second start without a new key sequence is refused.
- R7: Operation code 1 writes one word:
  - the word index is address register bits [7:2];
  - the stored word becomes the old word ANDed with the data register;
  - bit 15 reads 1 for exactly 8 polls after the start.
- R8: Operation code 4 erases a page:
  - every word of the 16-word page chosen by address bits [7:6] becomes 0xFFFFFFFF;
  - other pages are untouched;
  - busy lasts 64 cycles.
- R9: If the supply-low input is high in the finishing cycle, bit 12 is set and the array is not changed.
- R10: Operation code 0, run through the full start sequence, clears bits 13 and 12 and is busy for one cycle.
- R11: While busy, control writes are ignored, including a write in the finishing cycle. The operation uses the address and data captured at start, even if the registers change later.
- R12: After reset:
  - all registers read 0;
  - the unlock machine is in `LK_IDLE`;
  - every array word is 0xFFFFFFFF.
- R13: Any operation code other than 0, 1 or 4 is refused at start and sets bit 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 4 | Register (bits 3:2) and alias (bits 1:0) select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| low_volt | input | 1 | Supply-low indication, sampled when an operation finishes |
| arr_idx | input | 6 | Array word index for the read port |
| arr_word | output | 32 | Array word at `arr_idx` |

## Verification
Two events can fall in the same cycle: an operation finishing and firmware writing the control register. The bench provokes this by counting cycles from the start edge. It places a write that clears write-enable exactly on the finishing edge, then repeats the same write one cycle later. The first write must leave write-enable at 1, while the second must clear it. The operands captured at start are checked too: the address and data registers are rewritten during the busy window, and the array word that changes must be the one chosen at start.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_KEY  = 2'd1,
        REG_ADDR = 2'd2,
        REG_DATA = 2'd3
    } nvm_reg_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_ARMED,
        LK_HALF,
        LK_OPEN
    } lk_state_e;

    typedef enum logic {
        SQ_IDLE,
        SQ_RUN
    } sq_state_e;

    localparam logic [31:0] KEY_ARM    = 32'h0000_0000;
    localparam logic [31:0] KEY_FIRST  = 32'hAA99_6655;
    localparam logic [31:0] KEY_SECOND = 32'h5566_99AA;

    localparam logic [3:0] OP_NOP   = 4'd0;
    localparam logic [3:0] OP_WORD  = 4'd1;
    localparam logic [3:0] OP_ERASE = 4'd4;

    localparam int CB_START = 15;
    localparam int CB_WEN   = 14;
    localparam int CB_WERR  = 13;
    localparam int CB_LVERR = 12;

    function automatic logic [31:0] apply_alias(
        input logic [31:0] cur,
        input logic [31:0] wd,
        input logic [1:0]  al
    );
        logic [31:0] res;
        case (al)
            2'd1:    res = cur & ~wd;
            2'd2:    res = cur | wd;
            default: res = wd;
        endcase
        return res;
    endfunction

    function automatic logic op_legal(input logic [3:0] op);
        return (op == OP_NOP) || (op == OP_WORD) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/nvm_unlock_fsm.sv
module nvm_unlock_fsm
    import nvm_prog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_val,
    input  logic        other_acc,
    input  logic        start_try,
    output logic        unlocked
);

    lk_state_e state_q;
    lk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            if (key_val == KEY_ARM) begin
                state_d = LK_ARMED;
            end else begin
                unique case (state_q)
                    LK_IDLE:  state_d = LK_IDLE;
                    LK_ARMED: state_d = (key_val == KEY_FIRST)  ? LK_HALF : LK_IDLE;
                    LK_HALF:  state_d = (key_val == KEY_SECOND) ? LK_OPEN : LK_IDLE;
                    LK_OPEN:  state_d = LK_IDLE;
                endcase
            end
        end else if (start_try) begin
            state_d = LK_IDLE;
        end else if (other_acc) begin
            unique case (state_q)
                LK_IDLE:  state_d = LK_IDLE;
                LK_ARMED: state_d = LK_IDLE;
                LK_HALF:  state_d = LK_IDLE;
                LK_OPEN:  state_d = LK_OPEN;
            endcase
        end
    end

    always_comb begin
        unlocked = (state_q == LK_OPEN);
    end

endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
    import nvm_prog_pkg::*;
#(
    parameter int AW     = 6,
    parameter int WR_CYC = 8,
    parameter int ER_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [3:0]    go_op,
    input  logic [AW-1:0] go_idx,
    input  logic [31:0]   go_data,
    input  logic          low_volt,
    output logic          busy,
    output logic          fin,
    output logic          fin_lv,
    output logic          fin_nop,
    output logic          do_write,
    output logic          do_erase,
    output logic [AW-1:0] op_idx,
    output logic [31:0]   op_data
);

    localparam int MAXC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    sq_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    op_q;
    logic [CW-1:0] load_val;

    always_comb begin
        if (go_op == OP_WORD) begin
            load_val = CW'(WR_CYC);
        end else if (go_op == OP_ERASE) begin
            load_val = CW'(ER_CYC);
        end else begin
            load_val = CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_NOP;
            op_idx  <= '0;
            op_data <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        state_q <= SQ_RUN;
                        cnt_q   <= load_val;
                        op_q    <= go_op;
                        op_idx  <= go_idx;
                        op_data <= go_data;
                    end
                end
                SQ_RUN: begin
                    if (cnt_q == CW'(1)) begin
                        state_q <= SQ_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        busy     = (state_q == SQ_RUN);
        fin      = busy && (cnt_q == CW'(1));
        fin_nop  = fin && (op_q == OP_NOP);
        fin_lv   = fin && !fin_nop && low_volt;
        do_write = fin && !low_volt && (op_q == OP_WORD);
        do_erase = fin && !low_volt && (op_q == OP_ERASE);
    end

endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array #(
    parameter int WORDS      = 64,
    parameter int PAGE_WORDS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     er_en,
    input  logic [$clog2(WORDS)-1:0] idx,
    input  logic [31:0]              wdata,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [31:0]              rd_data
);

    localparam int AW  = $clog2(WORDS);
    localparam int PGB = $clog2(PAGE_WORDS);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '1;
            end
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (er_en && ((AW'(i) >> PGB) == (idx >> PGB))) begin
                    mem[i] <= '1;
                end else if (wr_en && (AW'(i) == idx)) begin
                    mem[i] <= mem[i] & wdata;
                end
            end
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
    import nvm_prog_pkg::*;
#(
    parameter int WORDS      = 64,
    parameter int PAGE_WORDS = 16,
    parameter int WR_CYC     = 8,
    parameter int ER_CYC     = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [3:0]               bus_sel,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    input  logic                     low_volt,
    input  logic [$clog2(WORDS)-1:0] arr_idx,
    output logic [31:0]              arr_word
);

    localparam int AW = $clog2(WORDS);

    nvm_reg_e    reg_sel;
    logic [1:0]  al_sel;
    logic        wen_q, werr_q, lverr_q;
    logic [3:0]  op_q;
    logic [31:0] addr_q, data_q, key_q;
    logic [31:0] ctrl_cur, ctrl_new;
    logic        ctrl_wr, key_wr, other_acc;
    logic        start_req, start_ok, start_bad;
    logic        lk_open;
    logic        seq_busy, seq_fin, seq_fin_lv, seq_fin_nop;
    logic        seq_do_write, seq_do_erase;
    logic [AW-1:0] seq_idx;
    logic [31:0]   seq_data;

    always_comb begin
        reg_sel   = nvm_reg_e'(bus_sel[3:2]);
        al_sel    = bus_sel[1:0];
        ctrl_cur  = '0;
        ctrl_cur[CB_START] = seq_busy;
        ctrl_cur[CB_WEN]   = wen_q;
        ctrl_cur[CB_WERR]  = werr_q;
        ctrl_cur[CB_LVERR] = lverr_q;
        ctrl_cur[3:0]      = op_q;
        ctrl_new  = apply_alias(ctrl_cur, bus_wdata, al_sel);
        ctrl_wr   = bus_wr && (reg_sel == REG_CTRL);
        key_wr    = bus_wr && (reg_sel == REG_KEY);
        other_acc = (bus_wr || bus_rd) && (reg_sel != REG_KEY);
        start_req = ctrl_wr && !seq_busy && ctrl_new[CB_START];
        start_ok  = start_req && lk_open && ctrl_new[CB_WEN] && op_legal(ctrl_new[3:0]);
        start_bad = start_req && !start_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wen_q   <= 1'b0;
            werr_q  <= 1'b0;
            lverr_q <= 1'b0;
            op_q    <= OP_NOP;
            addr_q  <= '0;
            data_q  <= '0;
            key_q   <= '0;
        end else begin
            if (ctrl_wr && !seq_busy) begin
                wen_q <= ctrl_new[CB_WEN];
                op_q  <= ctrl_new[3:0];
            end
            if (start_bad) begin
                werr_q <= 1'b1;
            end else if (seq_fin_nop) begin
                werr_q <= 1'b0;
            end
            if (seq_fin_lv) begin
                lverr_q <= 1'b1;
            end else if (seq_fin_nop) begin
                lverr_q <= 1'b0;
            end
            if (bus_wr && (reg_sel == REG_ADDR)) begin
                addr_q <= apply_alias(addr_q, bus_wdata, al_sel);
            end
            if (bus_wr && (reg_sel == REG_DATA)) begin
                data_q <= apply_alias(data_q, bus_wdata, al_sel);
            end
            if (key_wr) begin
                key_q <= apply_alias(key_q, bus_wdata, al_sel);
            end
        end
    end

    always_comb begin
        unique case (reg_sel)
            REG_CTRL: bus_rdata = ctrl_cur;
            REG_KEY:  bus_rdata = '0;
            REG_ADDR: bus_rdata = addr_q;
            REG_DATA: bus_rdata = data_q;
        endcase
    end

    nvm_unlock_fsm u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_val   (apply_alias(key_q, bus_wdata, al_sel)),
        .other_acc (other_acc),
        .start_try (start_req),
        .unlocked  (lk_open)
    );

    nvm_op_seq #(
        .AW     (AW),
        .WR_CYC (WR_CYC),
        .ER_CYC (ER_CYC)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (start_ok),
        .go_op    (ctrl_new[3:0]),
        .go_idx   (addr_q[AW+1:2]),
        .go_data  (data_q),
        .low_volt (low_volt),
        .busy     (seq_busy),
        .fin      (seq_fin),
        .fin_lv   (seq_fin_lv),
        .fin_nop  (seq_fin_nop),
        .do_write (seq_do_write),
        .do_erase (seq_do_erase),
        .op_idx   (seq_idx),
        .op_data  (seq_data)
    );

    nvm_word_array #(
        .WORDS      (WORDS),
        .PAGE_WORDS (PAGE_WORDS)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seq_do_write),
        .er_en   (seq_do_erase),
        .idx     (seq_idx),
        .wdata   (seq_data),
        .rd_idx  (arr_idx),
        .rd_data (arr_word)
    );

endmodule

// File: rtl/nvm_prog_chk.sv
module nvm_prog_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [3:0]    bus_sel,
    input logic          busy,
    input logic          werr,
    input logic          lverr,
    input logic          wen,
    input logic          unlocked,
    input logic [AW-1:0] arr_idx,
    input logic [31:0]   arr_word
);

    assert_start_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && (bus_sel[3:2] == 2'd0) && unlocked));

    assert_open_after_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && (bus_sel[3:2] == 2'd1)));

    assert_werr_from_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(werr) |-> $past(bus_wr && (bus_sel[3:2] == 2'd0)));

    assert_unlock_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !unlocked);

    assert_array_moves_at_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(arr_idx) && !$stable(arr_word)) |-> $fell(busy));

    assert_lverr_at_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lverr) |-> $fell(busy));

    assert_ctrl_frozen_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(wen));

endmodule

bind nvm_prog_ctrl nvm_prog_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_sel  (bus_sel),
    .busy     (seq_busy),
    .werr     (werr_q),
    .lverr    (lverr_q),
    .wen      (wen_q),
    .unlocked (lk_open),
    .arr_idx  (arr_idx),
    .arr_word (arr_word)
);

// File: tb/nvm_prog_ctrl_tb_top.sv
module nvm_prog_ctrl_tb_top;

    localparam logic [1:0] RC = 2'd0, RK = 2'd1, RA = 2'd2, RD = 2'd3;
    localparam logic [1:0] AR = 2'd0, AC = 2'd1, AS = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_sel = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        low_volt = 1'b0;
    logic [5:0]  arr_idx = '0;
    logic [31:0] arr_word;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] model [64];

    always #10 clk = ~clk;

    nvm_prog_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .low_volt  (low_volt),
        .arr_idx   (arr_idx),
        .arr_word  (arr_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] r, input logic [1:0] a, input logic [31:0] d);
        bus_sel = {r, a};
        bus_wdata = d;
        bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] r, output logic [31:0] v);
        bus_sel = {r, 2'd3};
        bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic arr_chk(input string tag, input int i);
        arr_idx = 6'(i);
        #1 check($sformatf("%s word %0d", tag, i), arr_word, model[i]);
    endtask

    task automatic keys();
        wr(RK, AR, 32'h0000_0000);
        wr(RK, AR, 32'hAA99_6655);
        wr(RK, AR, 32'h5566_99AA);
    endtask

    task automatic launch(input logic [3:0] op);
        wr(RC, AR, {28'd0, op});
        wr(RC, AS, 32'h4000);
        keys();
        wr(RC, AS, 32'h8000);
    endtask

    task automatic wait_done(output int n);
        logic [31:0] v;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            rd(RC, v);
            if (!v[15]) break;
            n++;
        end
    endtask

    task automatic do_op(input logic [3:0] op, input int word, input logic [31:0] d,
                         input int exp_cyc, input string tag);
        int n;
        wr(RA, AR, 32'(word) << 2);
        wr(RD, AR, d);
        launch(op);
        wait_done(n);
        check($sformatf("%s busy cycles", tag), 32'(n), 32'(exp_cyc));
        wr(RC, AC, 32'h4000);
    endtask

    task automatic nop_clear(input string tag);
        logic [31:0] v;
        int n;
        launch(4'd0);
        wait_done(n);
        check($sformatf("%s NOP busy", tag), 32'(n), 32'd1);
        rd(RC, v);
        check($sformatf("%s flags cleared", tag), v, 32'h4000);
        wr(RC, AC, 32'h4000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, e;
        int n;
        for (int i = 0; i < 64; i++) model[i] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(RC, v); check("R12 ctrl", v, 32'h0);
        rd(RA, v); check("R12 addr", v, 32'h0);
        rd(RD, v); check("R12 data", v, 32'h0);
        for (int i = 0; i < 64; i += 21) arr_chk("R12", i);

        // R1 alias arithmetic sweep on address and data registers
        for (int p = 0; p < 6; p++) begin
            logic [31:0] rv, sv, cv;
            rv = 32'hA5C3_0F1E ^ (32'h1111_1111 * 32'(p));
            sv = 32'h0F00_00F0 << p;
            cv = 32'hC0C0_3003 >> p;
            for (int r = 2; r < 4; r++) begin
                wr(2'(r), AR, rv);
                rd(2'(r), v); check("R1 raw", v, rv);
                wr(2'(r), AS, sv);
                e = rv | sv;
                rd(2'(r), v); check("R1 set", v, e);
                wr(2'(r), AC, cv);
                e = e & ~cv;
                rd(2'(r), v); check("R1 clear", v, e);
                wr(2'(r), 2'd3, rv ^ 32'hFFFF);
                rd(2'(r), v); check("R1 raw alt", v, rv ^ 32'hFFFF);
            end
        end

        // R2 control layout and key read
        wr(RC, AR, 32'h7FFF_7FFF);
        rd(RC, v); check("R2 ctrl writable bits", v, 32'h0000_400F);
        wr(RK, AR, 32'h1234_5678);
        rd(RK, v); check("R2 key reads zero", v, 32'h0);
        wr(RC, AR, 32'h0);

        // R3 R7 word write sweep over every word
        for (int i = 0; i < 64; i++) begin
            e = ~((32'h1 << (i % 32)) | (32'(i) << 20));
            do_op(4'd1, i, e, 8, "R7 sweep");
            model[i] = model[i] & e;
        end
        for (int i = 0; i < 64; i++) arr_chk("R3 R7 sweep", i);
        for (int i = 0; i < 8; i++) begin
            e = 32'h0F0F_F0F0 ^ 32'(i);
            do_op(4'd1, i * 3, e, 8, "R7 and");
            model[i * 3] = model[i * 3] & e;
            arr_chk("R7 and", i * 3);
        end

        // R8 page erase of each page in turn
        for (int pg = 0; pg < 4; pg++) begin
            do_op(4'd4, pg * 16 + 5, 32'h0, 64, "R8 erase");
            for (int i = pg * 16; i < pg * 16 + 16; i++) model[i] = 32'hFFFF_FFFF;
            for (int i = 0; i < 64; i++) arr_chk($sformatf("R8 page%0d", pg), i);
            if (pg < 3) begin
                for (int i = (pg + 1) * 16; i < (pg + 2) * 16; i++) begin
                    do_op(4'd1, i, 32'h0000_FFFF, 8, "R8 refill");
                    model[i] = model[i] & 32'h0000_FFFF;
                end
            end
        end

        // R4 broken key sequences
        for (int c = 0; c < 4; c++) begin
            wr(RA, AR, 32'(9) << 2);
            wr(RD, AR, 32'h0);
            wr(RC, AR, 32'h4001);
            wr(RK, AR, 32'h0);
            case (c)
                0: begin wr(RK, AR, 32'h1234_5678); wr(RK, AR, 32'h5566_99AA); end
                1: begin wr(RK, AR, 32'h5566_99AA); wr(RK, AR, 32'hAA99_6655); end
                2: begin wr(RK, AR, 32'hAA99_6655); rd(RA, v); wr(RK, AR, 32'h5566_99AA); end
                default: begin wr(RK, AR, 32'hAA99_6655); wr(RD, AR, 32'h0); wr(RK, AR, 32'h5566_99AA); end
            endcase
            wr(RC, AS, 32'h8000);
            rd(RC, v); check($sformatf("R4 case%0d refused", c), v, 32'h6001);
            repeat (70) @(negedge clk);
            arr_chk($sformatf("R4 case%0d", c), 9);
            nop_clear("R10 after R4");
        end

        // R5 write-enable low
        wr(RA, AR, 32'(9) << 2);
        wr(RC, AR, 32'h1);
        keys();
        wr(RC, AS, 32'h8000);
        rd(RC, v); check("R5 wen low refused", v, 32'h2001);
        repeat (10) @(negedge clk);
        arr_chk("R5", 9);
        nop_clear("R10 after R5");

        // R6 unlock consumed by one start
        do_op(4'd1, 9, 32'hFFFF_00FF, 8, "R6 first");
        model[9] = model[9] & 32'hFFFF_00FF;
        wr(RD, AR, 32'h0);
        wr(RC, AR, 32'h4001);
        wr(RC, AS, 32'h8000);
        rd(RC, v); check("R6 second start refused", v, 32'h6001);
        repeat (10) @(negedge clk);
        arr_chk("R6", 9);
        nop_clear("R10 after R6");

        // R13 illegal code
        launch(4'd2);
        rd(RC, v); check("R13 code 2 refused", v, 32'h6002);
        nop_clear("R10 after R13");

        // R9 supply low at finish
        low_volt = 1'b1;
        wr(RA, AR, 32'(5) << 2);
        wr(RD, AR, 32'h0);
        launch(4'd1);
        wait_done(n);
        check("R9 busy cycles", 32'(n), 32'd8);
        low_volt = 1'b0;
        rd(RC, v); check("R9 lverr set", v, 32'h5001);
        arr_chk("R9 unchanged", 5);
        nop_clear("R10 after R9");

        // R11 control write on finishing edge, operand capture
        wr(RA, AR, 32'(40) << 2);
        wr(RD, AR, 32'hFFFF_0000);
        launch(4'd1);
        wr(RD, AR, 32'h0);
        wr(RA, AR, 32'h0);
        repeat (5) @(negedge clk);
        wr(RC, AC, 32'h4000);
        rd(RC, v); check("R11 finish-edge write ignored", v, 32'h4001);
        wr(RC, AC, 32'h4000);
        rd(RC, v); check("R11 later write applies", v, 32'h0001);
        model[40] = model[40] & 32'hFFFF_0000;
        arr_chk("R11 captured operands", 40);
        arr_chk("R11 new address untouched", 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule